// File: doc/BRIEF.md
# Double-Buffered Channel Code Bank

This block holds the codes of twenty converter channels behind a two-stage register structure. A serial target front end delivers a byte stream. It marks the beginning and end of each write transaction with single-cycle pulses and presents each received byte with a valid strobe. The first byte of a transaction is a pointer. Its three upper bits select a command and its five lower bits select a channel. In a write transaction the pointer is followed by pairs of bytes, most-significant first, and each pair forms one 16-bit word.

Every channel has a storage register, which writes fill, and an active register, whose code drives the parallel output. A hold input decides when stored codes reach the active registers. When hold is low, each written channel updates at once. When hold is high, the active registers freeze until hold falls, and then all of them load together. A word whose top bit is set also loads all of them while hold is high. Commands in the pointer byte can return one channel or all channels to mid-scale. A reset and a general-call reset pulse do the same for the whole bank.

Top module: `dac_regbank`

## Requirements
- R1: After `rst_n` is low or `gcall_rst` is pulsed, every storage and active register holds mid-scale 512 (200h), whatever the level of `upd_hold`.
- R2: A pointer byte with bits 7:5 = 000 selects the channel given in bits 4:0. The next two bytes form a word {first, second}, and its bits 9:0 become the channel's stored code. Bits 14:10 of the word have no effect.
- R3: While `upd_hold` is low, the written channel's active code on `act_codes` changes at the same clock edge that accepts the second byte of the word.
- R4: While `upd_hold` is high, `act_codes` stays unchanged under plain writes.
- R5: On the first edge that samples `upd_hold` low after it was high, all active registers load their stored codes together.
- R6: With `upd_hold` high, a word whose bit 15 is 1 loads every active register from storage, including the word just written. This happens at the edge that accepts its second byte and not earlier.
- R7: A pointer byte with bits 7:5 = 100 sets every storage and active register to mid-scale at once, regardless of `upd_hold`. The remaining bytes of that transaction are ignored.
- R8: A pointer byte with bits 7:5 = 010 sets only the channel in bits 4:0 to mid-scale, in both its storage and active register. All other channels are unchanged.
- R9: After each complete word the channel pointer advances by one, so consecutive words fill consecutive channels in one transaction.
- R10: A word addressed to a channel above 13h (19) changes no register, and its bit 15 triggers no load.
- R11: A transaction that ends after only the first byte of a word leaves that channel's stored code unchanged.
- R12: Bytes received outside a transaction, and every byte after a pointer whose bits 7:5 are not 000, 100 or 010, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gcall_rst | input | 1 | One-cycle general-call reset request |
| xfer_start | input | 1 | One-cycle pulse that opens a write transaction |
| xfer_stop | input | 1 | One-cycle pulse that closes the transaction |
| rx_vld | input | 1 | Byte strobe for `rx_byte` |
| rx_byte | input | 8 | Received byte |
| upd_hold | input | 1 | High freezes active registers; falling edge loads them all |
| act_codes | output | 200 | Active codes, channel n in bits [10n+9:10n] |

## Verification
On every cycle the assertions check four things. The active codes are mid-scale after a general-call reset. A channel written with hold low shows its new code on the next cycle. The active codes stay still while hold is high and nothing broadcasts or resets. Every active code equals its stored code after hold falls. The parser is also checked: it never issues a write to an out-of-range channel, and it stays quiet between transactions. Only the bench scenarios can show the effects that depend on the byte sequence. These include how a word is assembled from two bytes, the pointer auto-increment, the mask on bits 14:10, the broadcast that waits for the second byte, the discarded half-word, and the isolation of a single-channel reset.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_PTR,
        PS_MSB,
        PS_LSB,
        PS_DROP
    } pstate_e;

    localparam logic [2:0] CMD_WRITE   = 3'b000;
    localparam logic [2:0] CMD_RST_ALL = 3'b100;
    localparam logic [2:0] CMD_RST_ONE = 3'b010;

    localparam int PTR_W = 5;

    typedef struct packed {
        pstate_e          st;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       msb;
    } parse_t;

endpackage

// File: rtl/dac_byte_parser.sv
module dac_byte_parser
    import dac_pkg::*;
#(
    parameter int NCH = 20,
    parameter int CW  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gcall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] ch_o,
    output logic [CW-1:0]    code_o,
    output logic             bcast_o,
    output logic             rst_all_o,
    output logic             rst_one_o
);

    localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NCH - 1);
    localparam logic [PTR_W-1:0] PTR_TOP = '1;

    parse_t p_q, p_d;
    logic [14:0] word15;

    assign word15 = {p_q.msb[6:0], byte_i};

    always_comb begin
        p_d       = p_q;
        wr_en_o   = 1'b0;
        bcast_o   = 1'b0;
        rst_all_o = 1'b0;
        rst_one_o = 1'b0;
        ch_o      = p_q.ptr;
        code_o    = word15[CW-1:0];
        if (start_i) begin
            p_d.st = PS_PTR;
        end else if (stop_i) begin
            p_d.st = PS_IDLE;
        end else if (byte_vld_i) begin
            case (p_q.st)
                PS_PTR: begin
                    p_d.ptr = byte_i[PTR_W-1:0];
                    ch_o    = byte_i[PTR_W-1:0];
                    p_d.st  = PS_DROP;
                    case (byte_i[7:5])
                        CMD_WRITE:   p_d.st    = PS_MSB;
                        CMD_RST_ALL: rst_all_o = 1'b1;
                        CMD_RST_ONE: rst_one_o = (byte_i[PTR_W-1:0] <= LAST_CH);
                        default:     p_d.st    = PS_DROP;
                    endcase
                end
                PS_MSB: begin
                    p_d.msb = byte_i;
                    p_d.st  = PS_LSB;
                end
                PS_LSB: begin
                    if (p_q.ptr <= LAST_CH) begin
                        wr_en_o = 1'b1;
                        bcast_o = p_q.msb[7];
                    end
                    if (p_q.ptr != PTR_TOP) begin
                        p_d.ptr = p_q.ptr + 1'b1;
                    end
                    p_d.st = PS_MSB;
                end
                default: p_d.st = p_q.st;
            endcase
        end
        if (gcall_i) begin
            p_d       = '{st: PS_IDLE, ptr: '0, msb: '0};
            wr_en_o   = 1'b0;
            rst_all_o = 1'b0;
            rst_one_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{st: PS_IDLE, ptr: '0, msb: '0};
        end else begin
            p_q <= p_d;
        end
    end

    // R10: a write strobe never addresses a channel beyond the bank
    a_r10_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (ch_o <= LAST_CH));

    // R12: between transactions the parser issues no write or reset
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == PS_IDLE && !start_i) |-> !(wr_en_o || rst_all_o || rst_one_o));

    // R2: at most one bank operation per cycle
    a_r2_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, rst_all_o, rst_one_o}));

endmodule

// File: rtl/dac_chan_store.sv
module dac_chan_store
    import dac_pkg::*;
#(
    parameter int NCH = 20,
    parameter int CW  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gcall_i,
    input  logic             hold_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] ch_i,
    input  logic [CW-1:0]    code_i,
    input  logic             bcast_i,
    input  logic             rst_all_i,
    input  logic             rst_one_i,
    output logic [NCH*CW-1:0] act_o
);

    localparam int          IW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] st;
        logic [NCH-1:0][CW-1:0] act;
        logic                   hold;
    } bank_t;

    bank_t b_q, b_d;
    logic [IW-1:0] idx;

    assign idx = ch_i[IW-1:0];

    always_comb begin
        b_d      = b_q;
        b_d.hold = hold_i;
        if (gcall_i) begin
            for (int i = 0; i < NCH; i++) begin
                b_d.st[i]  = MID;
                b_d.act[i] = MID;
            end
        end else begin
            if (rst_all_i) begin
                for (int i = 0; i < NCH; i++) begin
                    b_d.st[i]  = MID;
                    b_d.act[i] = MID;
                end
            end else if (rst_one_i) begin
                b_d.st[idx]  = MID;
                b_d.act[idx] = MID;
            end else if (wr_en_i) begin
                b_d.st[idx] = code_i;
                if (!hold_i) begin
                    b_d.act[idx] = code_i;
                end
            end
            if ((wr_en_i && bcast_i) || (b_q.hold && !hold_i)) begin
                b_d.act = b_d.st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                b_q.st[i]  <= MID;
                b_q.act[i] <= MID;
            end
            b_q.hold <= 1'b0;
        end else begin
            b_q <= b_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign act_o[g*CW +: CW] = b_q.act[g];

            // R1: general-call reset leaves the channel at mid-scale
            a_r1_gcall_mid: assert property (@(posedge clk) disable iff (!rst_n)
                gcall_i |=> (b_q.act[g] == MID && b_q.st[g] == MID));

            // R3: transparent update while hold is low
            a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
                (!hold_i && wr_en_i && idx == IW'(g) && !gcall_i)
                |=> (b_q.act[g] == $past(code_i)));

            // R5: after hold falls the active code matches storage
            a_r5_fall_load: assert property (@(posedge clk) disable iff (!rst_n)
                (b_q.hold && !hold_i) |=> (b_q.act[g] == b_q.st[g]));
        end
    endgenerate

    // R4: active codes frozen while hold is high and nothing loads or resets
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !(wr_en_i && bcast_i) && !rst_all_i && !rst_one_i && !gcall_i)
        |=> $stable(b_q.act));

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_pkg::*;
#(
    parameter int NCH = 20,
    parameter int CW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gcall_rst,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    input  logic              upd_hold,
    output logic [NCH*CW-1:0] act_codes
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_ch;
    logic [CW-1:0]    wr_code;
    logic             wr_bcast;
    logic             rst_all;
    logic             rst_one;

    dac_byte_parser #(.NCH(NCH), .CW(CW)) parser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gcall_i   (gcall_rst),
        .start_i   (xfer_start),
        .stop_i    (xfer_stop),
        .byte_vld_i(rx_vld),
        .byte_i    (rx_byte),
        .wr_en_o   (wr_en),
        .ch_o      (wr_ch),
        .code_o    (wr_code),
        .bcast_o   (wr_bcast),
        .rst_all_o (rst_all),
        .rst_one_o (rst_one)
    );

    dac_chan_store #(.NCH(NCH), .CW(CW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gcall_i  (gcall_rst),
        .hold_i   (upd_hold),
        .wr_en_i  (wr_en),
        .ch_i     (wr_ch),
        .code_i   (wr_code),
        .bcast_i  (wr_bcast),
        .rst_all_i(rst_all),
        .rst_one_i(rst_one),
        .act_o    (act_codes)
    );

endmodule

// File: tb/dac_regbank_tb_top.sv
module dac_regbank_tb_top;

    localparam int NCH = 20;
    localparam int CW  = 10;
    localparam logic [CW-1:0] MID = 10'h200;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              gcall_rst = 1'b0;
    logic              xfer_start = 1'b0;
    logic              xfer_stop = 1'b0;
    logic              rx_vld = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic              upd_hold = 1'b0;
    logic [NCH*CW-1:0] act_codes;

    int n_run = 0;
    int n_fail = 0;
    logic [CW-1:0] e_st [NCH];
    logic [CW-1:0] e_act[NCH];

    dac_regbank #(.NCH(NCH), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .gcall_rst(gcall_rst),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .rx_vld(rx_vld), .rx_byte(rx_byte),
        .upd_hold(upd_hold), .act_codes(act_codes)
    );

    task automatic chk(string tag, int ch, logic [CW-1:0] exp);
        n_run++;
        if (act_codes[ch*CW +: CW] !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, act_codes[ch*CW +: CW], exp);
        end
    endtask

    task automatic check_bank(string tag);
        for (int i = 0; i < NCH; i++) chk(tag, i, e_act[i]);
    endtask

    task automatic all_mid();
        for (int i = 0; i < NCH; i++) begin
            e_st[i] = MID;
            e_act[i] = MID;
        end
    endtask

    task automatic put(logic [7:0] b);
        rx_vld = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic start_x();
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic stop_x();
        xfer_stop = 1'b1; @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic m_word(int ch, logic [7:0] msb, logic [7:0] lsb);
        if (ch < NCH) begin
            e_st[ch] = {msb[1:0], lsb};
            if (!upd_hold) e_act[ch] = {msb[1:0], lsb};
            if (msb[7]) for (int i = 0; i < NCH; i++) e_act[i] = e_st[i];
        end
    endtask

    task automatic write1(int ch, logic [7:0] msb, logic [7:0] lsb);
        start_x(); put({3'b000, 5'(ch)}); put(msb); put(lsb); m_word(ch, msb, lsb); stop_x();
    endtask

    task automatic set_hold(logic v);
        if (upd_hold && !v) for (int i = 0; i < NCH; i++) e_act[i] = e_st[i];
        upd_hold = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        all_mid(); check_bank("R1 reset");
    endtask

    task automatic t_transparent();
        write1(3, 8'h7E, 8'h5A);
        chk("R2 bits14:10 masked", 3, 10'h25A);
        check_bank("R3 transparent");
    endtask

    task automatic t_autoinc();
        start_x(); put(8'h05);
        put(8'h01); put(8'h23); m_word(5, 8'h01, 8'h23);
        put(8'h03); put(8'hC4); m_word(6, 8'h03, 8'hC4);
        stop_x();
        chk("R9 first word", 5, 10'h123);
        chk("R9 second word", 6, 10'h3C4);
        check_bank("R9 bank");
    endtask

    task automatic t_hold();
        set_hold(1'b1);
        write1(0, 8'h00, 8'h11);
        write1(1, 8'h02, 8'h22);
        chk("R4 held ch0", 0, MID);
        check_bank("R4 held bank");
        set_hold(1'b0);
        chk("R5 fall ch0", 0, 10'h011);
        chk("R5 fall ch1", 1, 10'h222);
        check_bank("R5 fall bank");
    endtask

    task automatic t_bcast();
        set_hold(1'b1);
        write1(10, 8'h01, 8'h00);
        chk("R4 no bcast", 10, MID);
        start_x(); put(8'h0B); put(8'h81);
        chk("R6 not after first byte", 10, MID);
        put(8'h55); m_word(11, 8'h81, 8'h55); stop_x();
        chk("R6 bcast ch10", 10, 10'h100);
        chk("R6 bcast ch11", 11, 10'h155);
        check_bank("R6 bank");
        set_hold(1'b0);
    endtask

    task automatic t_partial();
        start_x(); put(8'h07); put(8'h03); stop_x();
        set_hold(1'b1); set_hold(1'b0);
        chk("R11 half word", 7, MID);
        write1(7, 8'h00, 8'h09);
        chk("R11 fresh word", 7, 10'h009);
    endtask

    task automatic t_range();
        write1(20, 8'h83, 8'hFF);
        check_bank("R10 ptr 14h");
        start_x(); put(8'h13);
        put(8'h02); put(8'h77); m_word(19, 8'h02, 8'h77);
        put(8'h81); put(8'h99); m_word(20, 8'h81, 8'h99);
        stop_x();
        chk("R10 ch19 written", 19, 10'h277);
        check_bank("R10 overflow ignored");
    endtask

    task automatic t_rst_one();
        write1(2, 8'h01, 8'h02);
        write1(4, 8'h01, 8'h04);
        start_x(); put(8'h42); put(8'h03); put(8'h33); stop_x();
        e_st[2] = MID; e_act[2] = MID;
        chk("R8 addressed", 2, MID);
        chk("R8 neighbour", 4, 10'h104);
        check_bank("R8 bank");
    endtask

    task automatic t_rst_all();
        set_hold(1'b1);
        write1(8, 8'h03, 8'h01);
        start_x(); put(8'h80); put(8'h00); put(8'h12); stop_x();
        all_mid();
        check_bank("R7 all mid held");
        set_hold(1'b0);
        check_bank("R7 storage mid");
    endtask

    task automatic t_ignored();
        write1(9, 8'h00, 8'h40);
        put(8'h09); put(8'h03); put(8'hFF);
        chk("R12 outside txn", 9, 10'h040);
        start_x(); put(8'hE9); put(8'h03); put(8'hFF); stop_x();
        check_bank("R12 bad command");
    endtask

    task automatic t_gcall();
        write1(12, 8'h02, 8'h00);
        set_hold(1'b1);
        gcall_rst = 1'b1; @(negedge clk); gcall_rst = 1'b0;
        all_mid();
        check_bank("R1 gcall held");
        set_hold(1'b0);
        check_bank("R1 gcall storage");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_transparent();
        t_autoinc();
        t_hold();
        t_bcast();
        t_partial();
        t_range();
        t_rst_one();
        t_rst_all();
        t_ignored();
        t_gcall();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule